// File: doc/BRIEF.md
# Fractional Pixel Clock Generator

This block turns one of three source clock streams into a display pixel clock in two stages. The first stage is a fractional divider. It stretches each divided period to an integer number of source ticks, and an accumulator adds one extra tick often enough that the mean ratio is `N + B/A`. The second stage is an integer prescaler. It counts the divided pulses and advances the pixel clock once every `P` of them.

The source clocks come in as one-cycle tick enables on the system clock. A 2-bit selector chooses which one counts. When the block is disabled, its configuration (source, divider, fraction, prescale, idle level, active edge) is captured. While it is enabled, the captured values are held, so software reprograms it by dropping the enable, writing new values and raising the enable again. Outputs are a divided-clock enable, the pixel clock level, and a strobe that marks each active pixel clock edge.

Top module: `frac_pclk_gen`

## Requirements
- R1: While `en_i` is low, `pclk_o` equals `idle_lvl_i` from the previous cycle, and `mclk_ce_o` and `edge_stb_o` stay low. After reset all three outputs are 0.
- R2: The selector picks the tick bit as follows: 1 picks `src_tick_i[0]`, 2 picks `src_tick_i[1]` and 3 picks `src_tick_i[2]`. Ticks on unselected bits are ignored. Selector value 0 is unsupported and produces no `mclk_ce_o` pulse.
- R3: When `den_i` or `num_i` is 0, every divided period lasts exactly N selected source ticks, where N is the captured `div_num_i`.
- R4: When both `den_i` (A) and `num_i` (B, with B < A) are nonzero, divided period k (k = 0 from enable) lasts N + floor(k·B/A) − floor((k−1)·B/A) ticks for k ≥ 1, and N ticks for k = 0.
- R5: A `div_num_i` value of 0 or 1 behaves as 2.
- R6: `pclk_o` toggles once every `pre_m1_i + 1` `mclk_ce_o` pulses. The 6-bit field covers prescale factors 1 to 64.
- R7: If `neg_edge_i` is 1, `edge_stb_o` pulses exactly in the cycles where `pclk_o` falls. If it is 0, the pulses come exactly where `pclk_o` rises.
- R8: Configuration inputs are captured only while `en_i` is low. Changes while enabled have no effect on the outputs.
- R9: A `pclk_o` change while enabled happens in the same cycle as a `mclk_ce_o` pulse. `mclk_ce_o` rises one cycle after the selected tick that completes a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; configuration is captured while low |
| src_tick_i | input | 3 | Tick enables of the three source clocks |
| src_sel_i | input | 2 | Source selector (1, 2, 3; 0 unsupported) |
| div_num_i | input | 8 | Integer divider N (values below 2 act as 2) |
| den_i | input | 6 | Fraction denominator A |
| num_i | input | 6 | Fraction numerator B, must be below A |
| pre_m1_i | input | 6 | Prescale factor minus one |
| idle_lvl_i | input | 1 | Pixel clock level while disabled |
| neg_edge_i | input | 1 | 1: active edge is falling; 0: rising |
| mclk_ce_o | output | 1 | One-cycle pulse per divided period |
| pclk_o | output | 1 | Pixel clock level |
| edge_stb_o | output | 1 | One-cycle pulse on each active pixel clock edge |

## Verification
The assertions check every cycle that the disabled state shows the idle level with both pulses quiet. They also check that pixel clock changes line up with divided pulses, that the strobe only marks a change toward the active edge's level, and that an unsupported source never yields a pulse. The lengths of the divided periods, the spread of the extra ticks across a fractional cycle, the prescale count and the holding of configuration during a run all need counts over many cycles. These are shown only by the bench scenarios, which compare them against a closed-form floor expression.

// File: rtl/fpclk_pkg.sv
package fpclk_pkg;

  typedef enum logic [1:0] {
    SRC_OFF      = 2'd0,
    SRC_CRYSTAL  = 2'd1,
    SRC_AUDIO    = 2'd2,
    SRC_FAST_PLL = 2'd3
  } src_e;

  // Pick the tick of the selected source; unsupported code yields nothing.
  function automatic logic src_pick(input logic [2:0] ticks, input src_e sel);
    case (sel)
      SRC_CRYSTAL:  return ticks[0];
      SRC_AUDIO:    return ticks[1];
      SRC_FAST_PLL: return ticks[2];
      default:      return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fpclk_frac_div.sv
module fpclk_frac_div #(
  parameter int DIV_W  = 8,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              src_tick,
  input  logic [DIV_W-1:0]  div_num,
  input  logic [FRAC_W-1:0] den,
  input  logic [FRAC_W-1:0] num,
  output logic              div_tick
);
  localparam int CNT_W = DIV_W + 1;

  // Returns {carry, next accumulator}; carry requests one extra source tick.
  function automatic logic [FRAC_W:0] frac_step(input logic [FRAC_W-1:0] acc,
                                                 input logic [FRAC_W-1:0] b,
                                                 input logic [FRAC_W-1:0] a);
    logic [FRAC_W:0] sum;
    logic [FRAC_W:0] rem;
    sum = {1'b0, acc} + {1'b0, b};
    rem = sum - {1'b0, a};
    if (a == '0 || b == '0) return {1'b0, acc};
    if (sum >= {1'b0, a}) return {1'b1, rem[FRAC_W-1:0]};
    return sum;
  endfunction

  logic [CNT_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic              extra_q;
  logic [CNT_W-1:0]  period_len;
  logic [FRAC_W:0]   step;

  assign period_len = {1'b0, div_num} + CNT_W'(extra_q);
  assign step       = frac_step(acc_q, num, den);
  assign div_tick   = run && src_tick && (cnt_q == period_len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      extra_q <= 1'b0;
    end else if (!run) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      extra_q <= 1'b0;
    end else if (src_tick) begin
      if (div_tick) begin
        cnt_q   <= '0;
        extra_q <= step[FRAC_W];
        acc_q   <= step[FRAC_W-1:0];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/fpclk_prescale.sv
module fpclk_prescale #(
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             div_tick,
  input  logic [PRE_W-1:0] pre_m1,
  output logic             pix_tick
);
  logic [PRE_W-1:0] cnt_q;

  assign pix_tick = run && div_tick && (cnt_q == pre_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (pix_tick) cnt_q <= '0;
    else if (div_tick) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/frac_pclk_gen.sv
module frac_pclk_gen
  import fpclk_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int FRAC_W = 6,
  parameter int PRE_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [2:0]        src_tick_i,
  input  logic [1:0]        src_sel_i,
  input  logic [DIV_W-1:0]  div_num_i,
  input  logic [FRAC_W-1:0] den_i,
  input  logic [FRAC_W-1:0] num_i,
  input  logic [PRE_W-1:0]  pre_m1_i,
  input  logic              idle_lvl_i,
  input  logic              neg_edge_i,
  output logic              mclk_ce_o,
  output logic              pclk_o,
  output logic              edge_stb_o
);
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
    return (d < MIN_DIV) ? MIN_DIV : d;
  endfunction

  // Captured configuration, frozen while running.
  src_e              run_sel;
  logic [DIV_W-1:0]  run_div;
  logic [FRAC_W-1:0] run_den;
  logic [FRAC_W-1:0] run_num;
  logic [PRE_W-1:0]  run_pre;
  logic              run_neg;

  // Named internal events.
  logic sel_tick;
  logic div_tick;
  logic pix_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_sel <= SRC_OFF;
      run_div <= MIN_DIV;
      run_den <= '0;
      run_num <= '0;
      run_pre <= '0;
      run_neg <= 1'b0;
    end else if (!en_i) begin
      run_sel <= src_e'(src_sel_i);
      run_div <= eff_div(div_num_i);
      run_den <= den_i;
      run_num <= num_i;
      run_pre <= pre_m1_i;
      run_neg <= neg_edge_i;
    end
  end

  assign sel_tick = src_pick(src_tick_i, run_sel);

  fpclk_frac_div #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (en_i),
    .src_tick (sel_tick),
    .div_num  (run_div),
    .den      (run_den),
    .num      (run_num),
    .div_tick (div_tick)
  );

  fpclk_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (en_i),
    .div_tick (div_tick),
    .pre_m1   (run_pre),
    .pix_tick (pix_tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mclk_ce_o  <= 1'b0;
      pclk_o     <= 1'b0;
      edge_stb_o <= 1'b0;
    end else if (!en_i) begin
      mclk_ce_o  <= 1'b0;
      pclk_o     <= idle_lvl_i;
      edge_stb_o <= 1'b0;
    end else begin
      mclk_ce_o  <= div_tick;
      // Falling edge when current level is 1, rising when it is 0.
      edge_stb_o <= pix_tick && (pclk_o == run_neg);
      if (pix_tick) pclk_o <= ~pclk_o;
    end
  end

endmodule

// File: rtl/frac_pclk_chk.sv
module frac_pclk_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_i,
  input logic       idle_lvl_i,
  input logic       mclk_ce_o,
  input logic       pclk_o,
  input logic       edge_stb_o,
  input logic       run_neg,
  input logic [1:0] run_sel
);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (pclk_o == $past(idle_lvl_i)) && !mclk_ce_o && !edge_stb_o);

  // R9
  pclk_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_i) && (pclk_o != $past(pclk_o))) |-> mclk_ce_o);

  // R7
  edge_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_stb_o |-> (pclk_o != $past(pclk_o)) && (pclk_o == !run_neg));

  // R2
  no_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_i) && (run_sel == 2'd0)) |-> !mclk_ce_o);

endmodule

bind frac_pclk_gen frac_pclk_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_i       (en_i),
  .idle_lvl_i (idle_lvl_i),
  .mclk_ce_o  (mclk_ce_o),
  .pclk_o     (pclk_o),
  .edge_stb_o (edge_stb_o),
  .run_neg    (run_neg),
  .run_sel    (run_sel)
);

// File: tb/test_frac_pclk_gen.sv
`timescale 1ns/1ps
module test_frac_pclk_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_i = 1'b0;
  logic [2:0] src_tick_i = '0;
  logic [1:0] src_sel_i = '0;
  logic [7:0] div_num_i = 8'd2;
  logic [5:0] den_i = '0;
  logic [5:0] num_i = '0;
  logic [5:0] pre_m1_i = '0;
  logic       idle_lvl_i = 1'b0;
  logic       neg_edge_i = 1'b0;
  logic       mclk_ce_o, pclk_o, edge_stb_o;

  frac_pclk_gen i_frac_pclk_gen (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .src_tick_i(src_tick_i),
    .src_sel_i(src_sel_i), .div_num_i(div_num_i), .den_i(den_i), .num_i(num_i),
    .pre_m1_i(pre_m1_i), .idle_lvl_i(idle_lvl_i), .neg_edge_i(neg_edge_i),
    .mclk_ce_o(mclk_ce_o), .pclk_o(pclk_o), .edge_stb_o(edge_stb_o)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Expected configuration and monitor state.
  int    e_sel, e_d, e_a, e_b, e_p, e_neg;
  int    k, ticks, mcnt, pulses;
  bit    mon_on = 1'b0;
  logic  last_p;
  string sc_tag = "R3";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Period length from the closed-form spread of B/A over periods.
  function automatic int exp_len(input int kk);
    if (kk == 0 || e_a == 0 || e_b == 0) return e_d;
    return e_d + (kk * e_b) / e_a - ((kk - 1) * e_b) / e_a;
  endfunction

  always @(negedge clk) begin
    if (mon_on) begin
      if (mclk_ce_o) begin
        chk(ticks == exp_len(k), sc_tag, ticks, exp_len(k));
        k++;
        ticks = 0;
        mcnt++;
        pulses++;
      end
      if (pclk_o !== last_p) begin
        chk(mcnt == e_p, "R6", mcnt, e_p);
        chk(mclk_ce_o == 1'b1, "R9", int'(mclk_ce_o), 1);
        chk(edge_stb_o == (int'(pclk_o) != e_neg), "R7", int'(edge_stb_o),
            int'(int'(pclk_o) != e_neg));
        mcnt = 0;
        last_p = pclk_o;
      end else if (edge_stb_o) begin
        chk(1'b0, "R7", 1, 0);
      end
      if (e_sel != 0 && src_tick_i[e_sel-1]) ticks++;
    end
  end

  task automatic run_case(input string tag, input int sel, input int d, input int a,
                          input int b, input int p1, input bit idle, input bit neg,
                          input int cycles, input bit dense, input bit midchg);
    @(posedge clk); #1;
    en_i = 1'b0; src_tick_i = '0;
    src_sel_i = 2'(sel); div_num_i = 8'(d); den_i = 6'(a); num_i = 6'(b);
    pre_m1_i = 6'(p1); idle_lvl_i = idle; neg_edge_i = neg;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(pclk_o == idle, "R1", int'(pclk_o), int'(idle));
    chk(!mclk_ce_o && !edge_stb_o, "R1", int'(mclk_ce_o | edge_stb_o), 0);
    e_sel = sel; e_d = (d < 2) ? 2 : d; e_a = a; e_b = b; e_p = p1 + 1; e_neg = int'(neg);
    k = 0; ticks = 0; mcnt = 0; pulses = 0; sc_tag = tag; last_p = idle;
    @(posedge clk); #1;
    en_i = 1'b1; mon_on = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #1;
      src_tick_i = dense ? 3'b111 : 3'($urandom);
      if (midchg && i == cycles / 2) begin
        src_sel_i = 2'($urandom); div_num_i = 8'($urandom); den_i = 6'($urandom);
        num_i = 6'($urandom); pre_m1_i = 6'($urandom); neg_edge_i = ~neg_edge_i;
      end
    end
    @(posedge clk); #1;
    en_i = 1'b0; mon_on = 1'b0; src_tick_i = '0;
    if (sel == 0) chk(pulses == 0, "R2", pulses, 0);
    else          chk(pulses > 0, tag, pulses, 1);
  endtask

  initial begin
    #900000;
    chk(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pclk_o == 1'b0 && !mclk_ce_o && !edge_stb_o, "R1", int'(pclk_o), 0);
    rst_n = 1'b1;
    run_case("R3", 1, 4, 0, 0, 0, 1'b0, 1'b0, 400, 1'b0, 1'b0);
    run_case("R3", 3, 5, 9, 0, 1, 1'b1, 1'b0, 400, 1'b0, 1'b0);
    run_case("R4", 2, 3, 5, 2, 2, 1'b1, 1'b1, 600, 1'b0, 1'b0);
    run_case("R4", 1, 2, 7, 6, 0, 1'b0, 1'b1, 600, 1'b1, 1'b0);
    run_case("R5", 3, 0, 7, 0, 1, 1'b0, 1'b0, 300, 1'b0, 1'b0);
    run_case("R5", 1, 1, 4, 3, 0, 1'b1, 1'b1, 300, 1'b0, 1'b0);
    run_case("R2", 0, 3, 0, 0, 0, 1'b1, 1'b0, 300, 1'b1, 1'b0);
    run_case("R8", 2, 4, 11, 5, 1, 1'b0, 1'b1, 800, 1'b0, 1'b1);
    run_case("R6", 2, 2, 0, 0, 63, 1'b1, 1'b0, 700, 1'b1, 1'b0);
    for (int r = 0; r < 10; r++) begin
      int a = 1 + int'($urandom % 13);
      int b = int'($urandom % 32'(a));
      run_case(b == 0 ? "R3" : "R4", 1 + int'($urandom % 3), 2 + int'($urandom % 8), a, b,
               int'($urandom % 6), 1'($urandom), 1'($urandom), 700, 1'b0, 1'b0);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule